// File: doc/BRIEF.md
# Process-Slot Address Relocator

This block sits between a processor core and its caches and translation unit. It takes each virtual address the core issues and produces a modified address. A small process tag chooses one of many equal-sized slots. Any address that falls inside the lowest slot-sized window of the address space is moved into the slot that the tag selects. Addresses above that window, addresses issued while address translation is switched off, and addresses that carry maintenance operands for a single cache or TLB entry all pass through unchanged.

The result is registered and appears one clock after the request. A valid bit travels with it. The tag value comes from elsewhere on each request. The slot size and the tag width are parameters, with defaults of a 32 MB window and a 7-bit tag, which give 128 slots.

Top module: `slot_reloc_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_vld` is 0 and `out_addr` is 0.
- R2: A request with `in_vld`=1 produces `out_vld`=1 exactly one clock later. A cycle with `in_vld`=0 produces `out_vld`=0 one clock later.
- R3: When `xlat_en`=1, `maint`=0 and address bits [31:25] are zero, `out_addr` equals the input address with bits [31:25] replaced by `proc_tag`. This is the address plus `proc_tag` × 0x0200_0000.
- R4: An address at or above 0x0200_0000 passes through unchanged whatever the tag is.
- R5: The window boundary is exact. 0x01FF_FFFF is relocated and 0x0200_0000 is not.
- R6: A `proc_tag` of 0 gives the identity mapping for every address.
- R7: When `xlat_en`=0, `out_addr` equals the input address for any tag.
- R8: When `maint`=1, `out_addr` equals the input address for any tag and any `xlat_en`.
- R9: Address bits [24:0] are never changed, and `out_addr` is held when `in_vld`=0.
- R10: All 128 tag values place their value in bits [31:25] of a relocated output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request valid |
| in_addr | input | 32 | Virtual address from the core |
| proc_tag | input | 7 | Process slot tag |
| xlat_en | input | 1 | Address translation enabled |
| maint | input | 1 | Address is an entry-based maintenance operand |
| out_vld | output | 1 | Result valid, one cycle after the request |
| out_addr | output | 32 | Modified address |

## Verification
The bench targets the two addresses on either side of the window edge. A comparator that is off by one would either relocate 0x0200_0000 or leave 0x01FF_FFFF alone. It also sweeps all 128 tags so that a truncated tag or an adder that leaks carries into high bits is caught. It checks each bypass condition by itself with a nonzero tag, because a design that ignores the translation-enable bit or the maintenance flag would still look correct when the tag is zero. Idle cycles test that the output register holds its value and that the valid bit tracks the request with exactly one cycle of delay.

// File: rtl/slot_reloc_pkg.sv
package slot_reloc_pkg;

    localparam int ADDR_W = 32;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } req_bus_t;

    typedef enum logic [1:0] {
        PATH_PASS_HIGH = 2'd0,
        PATH_PASS_OFF  = 2'd1,
        PATH_PASS_MNT  = 2'd2,
        PATH_RELOCATE  = 2'd3
    } path_t;

    function automatic path_t pick_path(input logic in_window,
                                        input logic en,
                                        input logic mnt);
        if (mnt)            return PATH_PASS_MNT;
        else if (!en)       return PATH_PASS_OFF;
        else if (!in_window) return PATH_PASS_HIGH;
        else                return PATH_RELOCATE;
    endfunction

endpackage

// File: rtl/slot_reloc_window.sv
module slot_reloc_window #(
    parameter int AW     = 32,
    parameter int SLOT_W = 25
) (
    input  logic [AW-1:0] addr,
    output logic          in_window
);
    localparam int HI_W = AW - SLOT_W;
    assign in_window = (addr[AW-1:SLOT_W] == {HI_W{1'b0}});
endmodule

// File: rtl/slot_reloc_merge.sv
module slot_reloc_merge #(
    parameter int AW     = 32,
    parameter int SLOT_W = 25,
    parameter int TAG_W  = 7
) (
    input  logic [AW-1:0]    addr,
    input  logic [TAG_W-1:0] tag,
    input  slot_reloc_pkg::path_t path,
    output logic [AW-1:0]    addr_mod
);
    import slot_reloc_pkg::*;
    localparam int HI_W = AW - SLOT_W;
    logic [HI_W-1:0] hi_new;

    generate
        if (TAG_W >= HI_W) begin : g_wide
            assign hi_new = tag[HI_W-1:0];
        end else begin : g_narrow
            assign hi_new = {{(HI_W-TAG_W){1'b0}}, tag};
        end
    endgenerate

    always_comb begin
        addr_mod = addr;
        if (path == PATH_RELOCATE)
            addr_mod = {hi_new, addr[SLOT_W-1:0]};
    end
endmodule

// File: rtl/slot_reloc_top.sv
module slot_reloc_top #(
    parameter int TAG_W  = 7,
    parameter int SLOT_W = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_vld,
    input  logic [31:0] in_addr,
    input  logic [6:0]  proc_tag,
    input  logic        xlat_en,
    input  logic        maint,
    output logic        out_vld,
    output logic [31:0] out_addr
);
    import slot_reloc_pkg::*;

    logic     win;
    path_t    path;
    logic [ADDR_W-1:0] mod_addr;
    logic [TAG_W-1:0]  tag_int;
    req_bus_t q;

    generate
        if (TAG_W >= 7) begin : g_tag_ext
            assign tag_int = {{(TAG_W-7){1'b0}}, proc_tag};
        end else begin : g_tag_cut
            assign tag_int = proc_tag[TAG_W-1:0];
        end
    endgenerate

    slot_reloc_window #(.AW(ADDR_W), .SLOT_W(SLOT_W)) u_win (
        .addr      (in_addr),
        .in_window (win)
    );

    assign path = pick_path(win, xlat_en, maint);

    slot_reloc_merge #(.AW(ADDR_W), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_merge (
        .addr     (in_addr),
        .tag      (tag_int),
        .path     (path),
        .addr_mod (mod_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_vld;
            if (in_vld) q.addr <= mod_addr;
        end
    end

    assign out_vld  = q.vld;
    assign out_addr = q.addr;
endmodule

// File: rtl/slot_reloc_chk.sv
module slot_reloc_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_vld,
    input logic [31:0] in_addr,
    input logic [6:0]  proc_tag,
    input logic        xlat_en,
    input logic        maint,
    input logic        out_vld,
    input logic [31:0] out_addr
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    // R2
    vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> out_vld == $past(in_vld));

    // R9
    low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(in_vld) |-> out_addr[24:0] == $past(in_addr[24:0]));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(in_vld) |-> $stable(out_addr));

    // R4
    high_pass_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(in_vld) && $past(in_addr[31:25]) != 7'd0
        |-> out_addr == $past(in_addr));

    // R7
    off_pass_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(in_vld) && !$past(xlat_en) |-> out_addr == $past(in_addr));

    // R8
    mnt_pass_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(in_vld) && $past(maint) |-> out_addr == $past(in_addr));

    // R3
    reloc_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(in_vld) && $past(xlat_en) && !$past(maint)
        && $past(in_addr[31:25]) == 7'd0 |-> out_addr[31:25] == $past(proc_tag));
endmodule

bind slot_reloc_top slot_reloc_chk u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_addr(in_addr),
    .proc_tag(proc_tag), .xlat_en(xlat_en), .maint(maint),
    .out_vld(out_vld), .out_addr(out_addr)
);

// File: tb/sim_slot_reloc_top.sv
`timescale 1ns/1ps
module sim_slot_reloc_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        in_vld = 0;
    logic [31:0] in_addr = 0;
    logic [6:0]  proc_tag = 0;
    logic        xlat_en = 0;
    logic        maint = 0;
    logic        out_vld;
    logic [31:0] out_addr;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    slot_reloc_top u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request, sample one cycle later away from the edge
    task automatic xfer(input logic [31:0] a, input logic [6:0] t,
                        input logic en, input logic m, output logic [31:0] res);
        @(negedge clk);
        in_vld = 1; in_addr = a; proc_tag = t; xlat_en = en; maint = m;
        @(negedge clk);
        in_vld = 0;
        res = out_addr;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 vld", {31'd0, out_vld}, 32'd0);
        chk("R1 addr", out_addr, 32'd0);
        rst = 0;
        @(negedge clk);
        chk("R1 post vld", {31'd0, out_vld}, 32'd0);
    endtask

    task automatic t_relocate();
        logic [31:0] r;
        xfer(32'h0012_3456, 7'd5, 1, 0, r);
        chk("R3 reloc", r, 32'h0012_3456 + 32'd5 * 32'h0200_0000);
        chk("R2 vld", {31'd0, out_vld}, 32'd1);
        @(negedge clk);
        chk("R2 idle", {31'd0, out_vld}, 32'd0);
        chk("R9 hold", out_addr, 32'h0A12_3456);
    endtask

    task automatic t_high();
        logic [31:0] r;
        xfer(32'h8000_1234, 7'd99, 1, 0, r);
        chk("R4 high", r, 32'h8000_1234);
    endtask

    task automatic t_edge();
        logic [31:0] r;
        xfer(32'h01FF_FFFF, 7'd1, 1, 0, r);
        chk("R5 below", r, 32'h03FF_FFFF);
        xfer(32'h0200_0000, 7'd1, 1, 0, r);
        chk("R5 at", r, 32'h0200_0000);
    endtask

    task automatic t_zero();
        logic [31:0] r;
        xfer(32'h00AB_CDEF, 7'd0, 1, 0, r);
        chk("R6 flat", r, 32'h00AB_CDEF);
    endtask

    task automatic t_off();
        logic [31:0] r;
        xfer(32'h0000_4000, 7'd7, 0, 0, r);
        chk("R7 off", r, 32'h0000_4000);
    endtask

    task automatic t_maint();
        logic [31:0] r;
        xfer(32'h0100_0040, 7'd33, 1, 1, r);
        chk("R8 maint", r, 32'h0100_0040);
        xfer(32'h0100_0080, 7'd33, 0, 1, r);
        chk("R8 maint off", r, 32'h0100_0080);
    endtask

    task automatic t_sweep();
        logic [31:0] r;
        for (int t = 0; t < 128; t++) begin
            xfer(32'h0155_AA55, t[6:0], 1, 0, r);
            chk("R10 sweep", r, 32'h0155_AA55 + t * 32'h0200_0000);
        end
        xfer(32'h01FF_FFFF, 7'd127, 1, 0, r);
        chk("R9 low bits", {7'd0, r[24:0]}, 32'h01FF_FFFF);
    endtask

    initial begin
        t_reset();
        t_relocate();
        t_high();
        t_edge();
        t_zero();
        t_off();
        t_maint();
        t_sweep();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule